// File: doc/BRIEF.md
# Lane-Partitioned Saturating Integer ALU

This block is a 64-bit integer arithmetic unit whose datapath can be cut into independent lanes. One select input chooses the lane width. The choices are a single 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. One opcode is then applied to every lane in the same cycle. The carry chain of a single adder is broken at each lane boundary, so the same gates serve one wide sum or several narrow sums.

The operations are:
- add and subtract that wrap;
- add and subtract that clamp to the lane's range instead of overflowing;
- per-lane minimum and maximum;
- absolute value;
- a 16-bit multiply-accumulate into four internal accumulator lanes, for dot-product loops.

A signedness flag selects how lanes are interpreted. Every result appears on a registered output one clock after the operands are presented.

Top module: `simd_sat_alu`

## Requirements
- R1: While reset is asserted, the result is zero and all four accumulator lanes are zero, so a multiply-accumulate of zero operands issued right after reset returns zero.
- R2: Lane width is set by `laneSel`: 0 = one 64-bit lane, 1 = two 32-bit lanes, 2 = four 16-bit lanes, 3 = eight 8-bit lanes. Lane k occupies bits [k*w +: w]. Wrapping add (`opCode` 0) and wrapping subtract (`opCode` 1, opA minus opB) give each lane modulo 2^w, and no carry or borrow crosses a lane boundary.
- R3: With `isSigned`=1, saturating add (`opCode` 2) and saturating subtract (`opCode` 3) clamp a lane that overflows to its most positive value (0 followed by ones) or its most negative value (1 followed by zeros).
- R4: With `isSigned`=0, saturating add clamps an overflowing lane to all ones, and saturating subtract clamps an underflowing lane to zero.
- R5: Minimum (`opCode` 4) and maximum (`opCode` 5) pick, per lane, the smaller or larger of the opA and opB lanes. Lanes are compared as two's complement when `isSigned`=1 and as unsigned otherwise.
- R6: Absolute value (`opCode` 6) acts on opA only. With `isSigned`=1, a negative lane becomes its magnitude, and the most negative value gives the most positive value. With `isSigned`=0, the opA lane is passed through unchanged.
- R7: Multiply-accumulate (`opCode` 7) always uses four 16-bit lanes, whatever `laneSel` is. Each lane adds opA×opB to its accumulator and clamps the sum to the 16-bit signed range or unsigned range, chosen by `isSigned`. It stores the clamped value and returns it as that lane's result.
- R8: `accClear`=1 zeroes all accumulator lanes at the clock edge and takes priority over a multiply-accumulate in the same cycle, which then returns zero.
- R9: The accumulators keep their value through any cycle whose opcode is not 7 and whose `accClear` is 0.
- R10: Every opcode's result is registered: it appears one clock edge after its inputs and not before.
- R11: Wrapping add and subtract give the same result whatever the value of `isSigned`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| laneSel | input | 2 | Lane width select (0: 64, 1: 32, 2: 16, 3: 8 bits) |
| opCode | input | 3 | Operation select (0 add, 1 sub, 2 sat add, 3 sat sub, 4 min, 5 max, 6 abs, 7 mac) |
| isSigned | input | 1 | Interpret lanes as two's complement |
| accClear | input | 1 | Zero the accumulator lanes at the next edge |
| result | output | 64 | Registered result |

## Verification
Every opcode has the same latency: operands driven on a falling edge are captured at the next rising edge and can be read at the falling edge after it. The bench therefore drives on one falling edge and compares on the next one. For the latency test it also samples once just before the capturing rising edge, to confirm that the output still holds the earlier value. Accumulator effects are checked the same way. A clear or a hold shows up on the next multiply-accumulate, one edge after that instruction is driven. The bench tracks the expected accumulator contents itself.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDS = 3'd2,
    OP_SUBS = 3'd3,
    OP_MIN  = 3'd4,
    OP_MAX  = 3'd5,
    OP_ABS  = 3'd6,
    OP_MAC  = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LANE_64 = 2'd0,
    LANE_32 = 2'd1,
    LANE_16 = 2'd2,
    LANE_8  = 2'd3
  } laneSel_e;

  localparam int LANE_MASK_W = 3;

  // Strobes from decode to the datapath
  typedef struct packed {
    logic                   invertY;    // subtract: invert second adder input, carry-in 1
    logic                   zeroX;      // absolute value: compute 0 - opA
    logic                   saturate;   // clamp lanes that leave their range
    logic                   pickMin;
    logic                   pickMax;
    logic                   pickAbs;
    logic                   pickMac;
    logic                   signedOps;
    logic [LANE_MASK_W-1:0] laneMask;   // bytes per lane minus one
    logic                   accClear;
    logic                   accEnable;
  } aluCtrl_t;

endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic [1:0] laneSel,
  input  logic [2:0] opCode,
  input  logic       isSigned,
  input  logic       accClear,
  output aluCtrl_t   ctl
);

  aluOp_e   op;
  laneSel_e lanes;

  assign op    = aluOp_e'(opCode);
  assign lanes = laneSel_e'(laneSel);

  always_comb begin
    ctl = '0;
    ctl.signedOps = isSigned;
    ctl.accClear  = accClear;
    unique case (lanes)
      LANE_64: ctl.laneMask = 3'd7;
      LANE_32: ctl.laneMask = 3'd3;
      LANE_16: ctl.laneMask = 3'd1;
      LANE_8:  ctl.laneMask = 3'd0;
      default: ctl.laneMask = 3'd0;
    endcase
    unique case (op)
      OP_ADD:  ;
      OP_SUB:  ctl.invertY = 1'b1;
      OP_ADDS: ctl.saturate = 1'b1;
      OP_SUBS: begin
        ctl.invertY  = 1'b1;
        ctl.saturate = 1'b1;
      end
      OP_MIN: begin
        ctl.invertY = 1'b1;
        ctl.pickMin = 1'b1;
      end
      OP_MAX: begin
        ctl.invertY = 1'b1;
        ctl.pickMax = 1'b1;
      end
      OP_ABS: begin
        ctl.invertY  = 1'b1;
        ctl.zeroX    = 1'b1;
        ctl.saturate = 1'b1;
        ctl.pickAbs  = 1'b1;
      end
      OP_MAC: begin
        ctl.pickMac   = 1'b1;
        ctl.accEnable = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/simd_mac_lane.sv
module simd_mac_lane #(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic              signedOps,
  input  logic              accEnable,
  input  logic              accClear,
  output logic [LANE_W-1:0] accNext
);

  localparam int SUM_W = 2 * LANE_W + 3;
  localparam int EXT_W = SUM_W - LANE_W;
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((64'd1 << (LANE_W - 1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] S_MIN = ~S_MAX;
  localparam logic signed [SUM_W-1:0] U_MAX = SUM_W'((64'd1 << LANE_W) - 64'd1);

  logic        [LANE_W-1:0] accQ;
  logic signed [SUM_W-1:0]  aExt, bExt, cExt, product, total;
  logic signed [SUM_W-1:0]  hiLim, loLim;
  logic        [LANE_W-1:0] clamped;

  assign aExt    = {{EXT_W{signedOps & laneA[LANE_W-1]}}, laneA};
  assign bExt    = {{EXT_W{signedOps & laneB[LANE_W-1]}}, laneB};
  assign cExt    = {{EXT_W{signedOps & accQ[LANE_W-1]}}, accQ};
  assign product = aExt * bExt;
  assign total   = cExt + product;
  assign hiLim   = signedOps ? S_MAX : U_MAX;
  assign loLim   = signedOps ? S_MIN : '0;

  always_comb begin
    if (total > hiLim)      clamped = hiLim[LANE_W-1:0];
    else if (total < loLim) clamped = loLim[LANE_W-1:0];
    else                    clamped = total[LANE_W-1:0];
  end

  always_comb begin
    if (accClear)       accNext = '0;
    else if (accEnable) accNext = clamped;
    else                accNext = accQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accQ <= '0;
    else       accQ <= accNext;
  end

endmodule

// File: rtl/simd_alu_dpath.sv
module simd_alu_dpath
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MAC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluCtrl_t          ctl,
  output logic [DATA_W-1:0] result
);

  localparam int BYTES     = DATA_W / 8;
  localparam int MAC_LANES = DATA_W / MAC_W;
  localparam int IDX_W     = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [7:0]       xByte   [BYTES];
  logic [7:0]       yByte   [BYTES];
  logic [7:0]       sumByte [BYTES];
  logic [BYTES-1:0] carryIn, carryOut, ovfS, outU, ltS, ltU, xSign, aSign;
  logic [DATA_W-1:0] aluNext, macNext;

  // Byte slices of one adder; carry is cut where a lane starts
  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic [8:0] full;
    logic       carryTo7;

    assign xByte[i] = ctl.zeroX ? 8'h00 : opA[i*8 +: 8];
    assign yByte[i] = (ctl.zeroX ? opA[i*8 +: 8] : opB[i*8 +: 8]) ^ {8{ctl.invertY}};

    if (i == 0) begin : g_first
      assign carryIn[i] = ctl.invertY;
    end else begin : g_chain
      assign carryIn[i] = ((i & int'(ctl.laneMask)) == 0) ? ctl.invertY : carryOut[i-1];
    end

    assign full        = {1'b0, xByte[i]} + {1'b0, yByte[i]} + {8'd0, carryIn[i]};
    assign sumByte[i]  = full[7:0];
    assign carryOut[i] = full[8];
    assign carryTo7    = full[7] ^ xByte[i][7] ^ yByte[i][7];
    assign ovfS[i]     = carryTo7 ^ full[8];
    assign outU[i]     = full[8] ^ ctl.invertY;
    assign ltS[i]      = full[7] ^ ovfS[i];
    assign ltU[i]      = ~full[8];
    assign xSign[i]    = xByte[i][7];
    assign aSign[i]    = opA[i*8 + 7];
  end

  // Per-byte result selection using flags from the lane's top byte
  always_comb begin
    aluNext = '0;
    for (int i = 0; i < BYTES; i++) begin
      logic [IDX_W-1:0] top;
      logic             isTop, laneOvf, laneLt, posClamp;
      logic [7:0]       aB, bB, satB, outB;

      top      = IDX_W'(i) | IDX_W'(ctl.laneMask);
      isTop    = (int'(top) == i);
      laneOvf  = ctl.signedOps ? ovfS[top] : outU[top];
      laneLt   = ctl.signedOps ? ltS[top]  : ltU[top];
      posClamp = ctl.signedOps ? ~xSign[top] : ~ctl.invertY;
      aB       = opA[i*8 +: 8];
      bB       = opB[i*8 +: 8];

      if (ctl.signedOps && isTop) satB = posClamp ? 8'h7F : 8'h80;
      else                        satB = posClamp ? 8'hFF : 8'h00;

      if (ctl.pickMin)      outB = laneLt ? aB : bB;
      else if (ctl.pickMax) outB = laneLt ? bB : aB;
      else if (ctl.pickAbs) begin
        if (ctl.signedOps && aSign[top]) outB = laneOvf ? satB : sumByte[i];
        else                             outB = aB;
      end
      else if (ctl.saturate && laneOvf) outB = satB;
      else                              outB = sumByte[i];

      aluNext[i*8 +: 8] = outB;
    end
  end

  for (genvar l = 0; l < MAC_LANES; l++) begin : g_mac
    simd_mac_lane #(.LANE_W(MAC_W)) u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .laneA     (opA[l*MAC_W +: MAC_W]),
      .laneB     (opB[l*MAC_W +: MAC_W]),
      .signedOps (ctl.signedOps),
      .accEnable (ctl.accEnable),
      .accClear  (ctl.accClear),
      .accNext   (macNext[l*MAC_W +: MAC_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= ctl.pickMac ? macNext : aluNext;
  end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MAC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        laneSel,
  input  logic [2:0]        opCode,
  input  logic              isSigned,
  input  logic              accClear,
  output logic [DATA_W-1:0] result
);

  aluCtrl_t ctl;

  simd_alu_ctrl u_ctrl (
    .laneSel  (laneSel),
    .opCode   (opCode),
    .isSigned (isSigned),
    .accClear (accClear),
    .ctl      (ctl)
  );

  simd_alu_dpath #(.DATA_W(DATA_W), .MAC_W(MAC_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .ctl    (ctl),
    .result (result)
  );

endmodule

// File: rtl/simd_sat_alu_checker.sv
module simd_sat_alu_checker (
  input logic        clk,
  input logic        rstN,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [1:0]  laneSel,
  input logic [2:0]  opCode,
  input logic        isSigned,
  input logic        accClear,
  input logic [63:0] result
);

  // R2: full-width wrapping add matches a plain 64-bit sum
  a_r2_wide_add: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd0 && laneSel == 2'd0) |=> (result == $past(opA) + $past(opB)));

  // R3: two non-negative signed operands never produce a negative sum
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd2 && isSigned && laneSel == 2'd0 && !opA[63] && !opB[63])
      |=> !result[63]);

  // R4: unsigned saturating add never falls below its first operand
  a_r4_uns_floor: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd2 && !isSigned && laneSel == 2'd0) |=> (result >= $past(opA)));

  // R5: signed 64-bit minimum
  a_r5_signed_min: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd4 && isSigned && laneSel == 2'd0)
      |=> (result == (($signed($past(opA)) < $signed($past(opB))) ? $past(opA) : $past(opB))));

  // R6: signed byte-lane absolute value is never negative
  a_r6_abs_sign: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd6 && isSigned && laneSel == 2'd3)
      |=> ((result & 64'h8080_8080_8080_8080) == 64'd0));

  // R8: clear wins over a simultaneous multiply-accumulate
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (accClear && opCode == 3'd7) |=> (result == 64'd0));

endmodule

bind simd_sat_alu simd_sat_alu_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .opA      (opA),
  .opB      (opB),
  .laneSel  (laneSel),
  .opCode   (opCode),
  .isSigned (isSigned),
  .accClear (accClear),
  .result   (result)
);

// File: tb/simd_sat_alu_test.sv
`timescale 1ns/1ps
module simd_sat_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [1:0]  laneSel = '0;
  logic [2:0]  opCode = '0;
  logic        isSigned = 1'b0;
  logic        accClear = 1'b0;
  logic [63:0] result;

  int total = 0;
  int failed = 0;
  logic [15:0] accModel [4];

  always #5 clk = ~clk;

  simd_sat_alu uut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .laneSel(laneSel),
    .opCode(opCode), .isSigned(isSigned), .accClear(accClear), .result(result)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Lane-wise reference for opcodes 0..6
  function automatic logic [63:0] golden(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] sel, input logic [2:0] op, input bit sg);
    int w = 64 >> sel;
    int n = 64 / w;
    logic [63:0] r = '0;
    for (int l = 0; l < n; l++) begin
      logic signed [67:0] x, y, v, hi, lo;
      logic [63:0] m;
      m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      x  = 68'((a >> (l * w)) & m);
      y  = 68'((b >> (l * w)) & m);
      if (sg && x[w-1]) x = x - (68'sd1 <<< w);
      if (sg && y[w-1]) y = y - (68'sd1 <<< w);
      hi = sg ? (68'sd1 <<< (w - 1)) - 68'sd1 : (68'sd1 <<< w) - 68'sd1;
      lo = sg ? -(68'sd1 <<< (w - 1)) : 68'sd0;
      case (op)
        3'd0: v = x + y;
        3'd1: v = x - y;
        3'd2: v = x + y;
        3'd3: v = x - y;
        3'd4: v = (x < y) ? x : y;
        3'd5: v = (x < y) ? y : x;
        default: v = (sg && x < 0) ? -x : x;
      endcase
      if (op == 3'd2 || op == 3'd3 || op == 3'd6) begin
        if (v > hi) v = hi;
        if (v < lo) v = lo;
      end
      r = r | ((64'(v) & m) << (l * w));
    end
    return r;
  endfunction

  function automatic logic [63:0] macModel(input logic [63:0] a, input logic [63:0] b,
                                           input bit sg, input bit clr);
    logic [63:0] r = '0;
    if (clr) begin
      for (int l = 0; l < 4; l++) accModel[l] = '0;
      return '0;
    end
    for (int l = 0; l < 4; l++) begin
      longint av, bv, cv, s;
      av = sg ? longint'($signed(a[l*16 +: 16])) : longint'(a[l*16 +: 16]);
      bv = sg ? longint'($signed(b[l*16 +: 16])) : longint'(b[l*16 +: 16]);
      cv = sg ? longint'($signed(accModel[l])) : longint'(accModel[l]);
      s  = cv + av * bv;
      if (sg) begin
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
      end else begin
        if (s > 65535) s = 65535;
        if (s < 0) s = 0;
      end
      accModel[l] = 16'(s);
      r[l*16 +: 16] = 16'(s);
    end
    return r;
  endfunction

  // Drive on a falling edge, compare on the next falling edge
  task automatic step(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sel,
                      input logic [2:0] op, input bit sg, input bit clr, input string tag);
    logic [63:0] exp;
    opA = a; opB = b; laneSel = sel; opCode = op; isSigned = sg; accClear = clr;
    if (op == 3'd7) exp = macModel(a, b, sg, clr);
    else begin
      exp = golden(a, b, sel, op, sg);
      if (clr) void'(macModel(a, b, sg, 1'b1));
    end
    @(negedge clk);
    check(result, exp, tag);
  endtask

  task automatic t_reset;
    for (int l = 0; l < 4; l++) accModel[l] = '0;
    repeat (3) @(negedge clk);
    check(result, 64'd0, "R1 result during reset");
    rstN = 1'b1;
    step(64'd0, 64'd0, 2'd0, 3'd7, 1'b1, 1'b0, "R1 accumulator zero after reset");
  endtask

  task automatic t_wrap;
    step('1, 64'd1, 2'd0, 3'd0, 1'b0, 1'b0, "R2 64-bit carry through");
    check(result, 64'd0, "R2 64-bit literal");
    step(64'h0000_0000_FFFF_FFFF, 64'd1, 2'd0, 3'd0, 1'b0, 1'b0, "R2 carry across bit 32");
    step(64'h0000_0000_FFFF_FFFF, 64'd1, 2'd1, 3'd0, 1'b0, 1'b0, "R2 cut at 32");
    check(result, 64'd0, "R2 32-bit lanes literal");
    step('1, 64'h0101_0101_0101_0101, 2'd3, 3'd0, 1'b0, 1'b0, "R2 byte lanes");
    check(result, 64'd0, "R2 byte lanes literal");
    step(64'd0, 64'h0001_0001_0001_0001, 2'd2, 3'd1, 1'b0, 1'b0, "R2 borrow cut 16");
    check(result, '1, "R2 16-bit borrow literal");
    step(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'd1, 3'd1, 1'b0, 1'b0, "R2 sub 32");
    step(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'd1, 3'd1, 1'b1, 1'b0, "R11 sub signed flag");
    step('1, 64'h0101_0101_0101_0101, 2'd3, 3'd0, 1'b1, 1'b0, "R11 add signed flag");
    check(result, 64'd0, "R11 literal");
  endtask

  task automatic t_sat_signed;
    step(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd3, 3'd2, 1'b1, 1'b0, "R3 byte pos clamp");
    check(result, 64'h7F7F_7F7F_7F7F_7F7F, "R3 byte pos literal");
    step(64'h8080_8080_8080_8080, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 3'd2, 1'b1, 1'b0, "R3 byte neg clamp");
    check(result, 64'h8080_8080_8080_8080, "R3 byte neg literal");
    step(64'h8000_7FFF_0010_FFF0, 64'h0001_FFFF_0020_0005, 2'd2, 3'd3, 1'b1, 1'b0, "R3 16 sub mixed");
    step(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 2'd0, 3'd2, 1'b1, 1'b0, "R3 64 pos");
    check(result, 64'h7FFF_FFFF_FFFF_FFFF, "R3 64 literal");
    step(64'h8000_0000_7FFF_FFF0, 64'h0000_0001_0000_0020, 2'd1, 3'd3, 1'b1, 1'b0, "R3 32 sub");
  endtask

  task automatic t_sat_unsigned;
    step(64'hFF10_FF10_FF10_FF10, 64'h0101_0101_0101_0101, 2'd3, 3'd2, 1'b0, 1'b0, "R4 byte add");
    check(result, 64'hFF11_FF11_FF11_FF11, "R4 byte add literal");
    step(64'h0010_0000_0005_FFFF, 64'h0001_0001_0006_0001, 2'd2, 3'd3, 1'b0, 1'b0, "R4 16 sub floor");
    check(result, 64'h000F_0000_0000_FFFE, "R4 16 sub literal");
    step('1, 64'd5, 2'd0, 3'd2, 1'b0, 1'b0, "R4 64 add");
    step(64'd3, 64'd9, 2'd1, 3'd3, 1'b0, 1'b0, "R4 32 sub");
  endtask

  task automatic t_minmax;
    step(64'h8001_7F00_FF02_1080, 64'h7F02_8001_01FF_0880, 2'd3, 3'd4, 1'b1, 1'b0, "R5 byte min signed");
    step(64'h8001_7F00_FF02_1080, 64'h7F02_8001_01FF_0880, 2'd3, 3'd4, 1'b0, 1'b0, "R5 byte min unsigned");
    step(64'h8001_7F00_FF02_1080, 64'h7F02_8001_01FF_0880, 2'd2, 3'd5, 1'b1, 1'b0, "R5 16 max signed");
    step(64'h8001_7F00_FF02_1080, 64'h7F02_8001_01FF_0880, 2'd2, 3'd5, 1'b0, 1'b0, "R5 16 max unsigned");
    step(64'h8000_0000_0000_0000, 64'd1, 2'd0, 3'd4, 1'b1, 1'b0, "R5 64 min signed");
    check(result, 64'h8000_0000_0000_0000, "R5 64 literal");
    step(64'h8000_0000_0000_0000, 64'd1, 2'd1, 3'd5, 1'b0, 1'b0, "R5 32 max unsigned");
  endtask

  task automatic t_abs;
    step(64'h80FF_0100_817F_C040, 64'd0, 2'd3, 3'd6, 1'b1, 1'b0, "R6 byte signed");
    check(result, 64'h7F01_0100_7F7F_4040, "R6 byte literal");
    step(64'h80FF_0100_817F_C040, 64'd0, 2'd3, 3'd6, 1'b0, 1'b0, "R6 unsigned passthrough");
    check(result, 64'h80FF_0100_817F_C040, "R6 passthrough literal");
    step(64'h8000_FFFF_0003_7FFF, '1, 2'd2, 3'd6, 1'b1, 1'b0, "R6 16 signed");
    step(64'h8000_0000_0000_0000, 64'd0, 2'd0, 3'd6, 1'b1, 1'b0, "R6 64 most negative");
    check(result, 64'h7FFF_FFFF_FFFF_FFFF, "R6 64 literal");
  endtask

  task automatic t_mac;
    step(64'd0, 64'd0, 2'd2, 3'd7, 1'b1, 1'b1, "R8 clear");
    step(64'h0003_0003_FFFE_0001, 64'h0004_0004_0005_0007, 2'd2, 3'd7, 1'b1, 1'b0, "R7 first mac");
    check(result, 64'h000C_000C_FFF6_0007, "R7 first literal");
    step(64'h0003_0003_FFFE_0001, 64'h0004_0004_0005_0007, 2'd0, 3'd7, 1'b1, 1'b0, "R7 laneSel ignored");
    check(result, 64'h0018_0018_FFEC_000E, "R7 second literal");
    step(64'h7FFF_8000_0100_0001, 64'h7FFF_7FFF_0100_0001, 2'd3, 3'd7, 1'b1, 1'b0, "R7 signed clamp");
    check(result, 64'h7FFF_8000_7FFF_000F, "R7 clamp literal");
    step(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 2'd2, 3'd7, 1'b1, 1'b1, "R8 clear beats mac");
    check(result, 64'd0, "R8 literal");
    step(64'hFFFF_0002_0000_0010, 64'hFFFF_0003_0009_0010, 2'd2, 3'd7, 1'b0, 1'b0, "R7 unsigned");
    check(result, 64'hFFFF_0006_0000_0100, "R7 unsigned literal");
    step(64'h1234, 64'h5678, 2'd1, 3'd0, 1'b0, 1'b0, "R9 add between");
    step(64'hFFFF, 64'h1, 2'd3, 3'd5, 1'b1, 1'b0, "R9 max between");
    step(64'd0, 64'd0, 2'd2, 3'd7, 1'b0, 1'b0, "R9 accumulator held");
    check(result, 64'hFFFF_0006_0000_0100, "R9 held literal");
    step(64'h5, 64'h6, 2'd0, 3'd0, 1'b0, 1'b1, "R8 clear during add");
    step(64'd0, 64'd0, 2'd2, 3'd7, 1'b0, 1'b0, "R8 cleared by non-mac");
    check(result, 64'd0, "R8 non-mac clear literal");
  endtask

  task automatic t_latency;
    logic [63:0] prev;
    step(64'h10, 64'h20, 2'd0, 3'd0, 1'b0, 1'b0, "R10 prime");
    prev = result;
    opA = 64'h1000; opB = 64'h2000; opCode = 3'd1; laneSel = 2'd0; isSigned = 1'b0;
    #4;
    check(result, prev, "R10 not before edge");
    @(negedge clk);
    check(result, golden(64'h1000, 64'h2000, 2'd0, 3'd1, 1'b0), "R10 one edge later");
    for (int k = 0; k < 8; k++)
      step(64'h0102_0304_0506_0708 * (k + 1), 64'h1111_1111_1111_1111 ^ k,
           2'(k), 3'(k % 7), k[0], 1'b0, "R10 back to back");
  endtask

  task automatic t_mix;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b;
      logic [2:0] op;
      a  = {$urandom(), $urandom()};
      b  = {$urandom(), $urandom()};
      op = 3'($urandom_range(0, 7));
      if (k % 5 == 0) a[63:56] = 8'h80;
      step(a, b, 2'($urandom_range(0, 3)), op, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 15) == 0), "R10 mixed ops");
    end
  endtask

  initial begin
    #1_500_000;
    failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    t_reset();
    t_wrap();
    t_sat_signed();
    t_sat_unsigned();
    t_minmax();
    t_abs();
    t_mac();
    t_latency();
    t_mix();
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

endmodule